// File: doc/BRIEF.md
# Cross-Clock Mailbox Bridge

This block lets two ports, each running on its own clock, hand single 36-bit words to each other without touching the data queues. Each direction has one mailbox register. A port posts a word by raising chip select, enable, mailbox select and the write direction in one cycle. The word is then held in the mailbox. A "mail waiting" flag appears in the other port's clock domain. When the receiving port reads the mailbox, the flag clears and the slot frees up again.

Each direction is a one-deep stream. For the sending port, `*_send_ready` acts as ready. A qualified write is taken only on an edge where ready is high; on any other edge it is dropped and nothing changes. For the receiving port, `*_mail_full` acts as valid and `*_rdata` carries the payload. A qualified read takes the word only while valid is high. After a word is taken, the sender's ready stays low until the read acknowledgement has crossed back into the sender's domain. This stops unread mail from being overwritten.

Each direction has its own active-low reset. That reset clears the mailbox data and both halves of that direction's handshake. The opposite direction is left alone. Toggle signals cross the clock boundary through synchronizer chains; the data word itself crosses unsynchronized, because it is held stable for as long as the flag is up.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, both mailbox read buses show zero and both mail-waiting flags are low. Within SYNC_STAGES+1 cycles of its clock after reset is released, each send-ready is high.
- R2: A write from port A (cs=1, en=1, mbsel=1, wnr=1) taken while `a_send_ready` is high raises `b_mail_full` within SYNC_STAGES+2 port-B clock edges. `b_rdata` then equals the written word.
- R3: The same holds from port B to port A: a write from B raises `a_mail_full`, and `a_rdata` shows the word.
- R4: On the clock edge after an accepted write, the writer's send-ready is low. It stays low until the receiver has read the word.
- R5: A write attempted while send-ready is low is ignored. The waiting word is not replaced, and no second mail appears after the read.
- R6: A read from the receiving port (cs=1, en=1, mbsel=1, wnr=0) while its flag is high drops the flag on the next edge. The writer's send-ready returns high within SYNC_STAGES+2 writer clock edges.
- R7: While a mail-waiting flag is high, the read bus of that port holds a constant value.
- R8: A write with any one of cs, en or mbsel low, or with wnr=0, posts nothing: the flag stays low and send-ready stays high.
- R9: A read with mbsel or en low does not clear a waiting flag.
- R10: Asserting rst_ab_n clears the A-to-B mailbox to zero, clears `b_mail_full`, and leaves `a_send_ready` high after release. The B-to-A mail stays waiting with its word intact.
- R11: Both directions can hold mail at the same time, and each delivers its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ab_n | input | 1 | Active-low reset of the A-to-B mailbox |
| rst_ba_n | input | 1 | Active-low reset of the B-to-A mailbox |
| a_cs | input | 1 | Port A chip select |
| a_en | input | 1 | Port A access enable |
| a_mbsel | input | 1 | Port A mailbox path select |
| a_wnr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_wdata | input | DW | Word posted from port A |
| a_rdata | output | DW | B-to-A mailbox contents |
| a_mail_full | output | 1 | Mail from B waiting for port A |
| a_send_ready | output | 1 | A-to-B mailbox can take a word |
| b_cs | input | 1 | Port B chip select |
| b_en | input | 1 | Port B access enable |
| b_mbsel | input | 1 | Port B mailbox path select |
| b_wnr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_wdata | input | DW | Word posted from port B |
| b_rdata | output | DW | A-to-B mailbox contents |
| b_mail_full | output | 1 | Mail from A waiting for port B |
| b_send_ready | output | 1 | B-to-A mailbox can take a word |

## Verification
The properties assume certain things about the inputs:
- Each port's controls and write data are set up synchronously to that port's own clock.
- A direction's reset is held low for at least a few cycles of the slower clock, so the synchronizer chains on both sides clear.

The cross-domain property, that a waiting flag implies the sender is busy, relies on those resets acting on both halves at once. The stimulus changes every input one nanosecond after the edge of the clock it belongs to, and holds each reset low for several cycles of both clocks. The two clocks run at unrelated periods, so edges sometimes coincide and sometimes drift apart.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW = 36;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_dir_e;

  // Mailbox-path access of the requested direction this cycle.
  function automatic logic mbx_hit(input logic cs, input logic en,
                                   input logic sel, input logic wnr,
                                   input acc_dir_e dir);
    return cs & en & sel & (wnr == logic'(dir));
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DW          = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_req,
  output logic          rd_full,
  output logic [DW-1:0] rd_data
);
  logic          wrst_n, rrst_n;
  logic          req_tog, req_s;
  logic          ack_tog, ack_s;
  logic [DW-1:0] data_q;

  // Reset: asserted at once, released in step with each local clock.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  // Writer domain: holds the word and flips the request toggle.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack (.clk(wclk), .rst_n(wrst_n), .d(ack_tog), .q(ack_s));

  assign wr_ready = wrst_n & ~(req_tog ^ ack_s);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      req_tog <= 1'b0;
      data_q  <= '0;
    end else if (wr_req && wr_ready) begin
      req_tog <= ~req_tog;
      data_q  <= wr_data;
    end
  end

  // Reader domain: flag is the toggle mismatch; a read answers it.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_req (.clk(rclk), .rst_n(rrst_n), .d(req_tog), .q(req_s));

  assign rd_full = req_s ^ ack_tog;
  assign rd_data = data_q;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)                 ack_tog <= 1'b0;
    else if (rd_req && rd_full)  ack_tog <= ~ack_tog;
  end
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int DW          = MBX_DW,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_ab_n,
  input  logic          rst_ba_n,
  input  logic          a_cs,
  input  logic          a_en,
  input  logic          a_mbsel,
  input  logic          a_wnr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_mail_full,
  output logic          a_send_ready,
  input  logic          b_cs,
  input  logic          b_en,
  input  logic          b_mbsel,
  input  logic          b_wnr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_mail_full,
  output logic          b_send_ready
);
  logic a_wr, a_rd, b_wr, b_rd;

  assign a_wr = mbx_hit(a_cs, a_en, a_mbsel, a_wnr, ACC_WRITE);
  assign a_rd = mbx_hit(a_cs, a_en, a_mbsel, a_wnr, ACC_READ);
  assign b_wr = mbx_hit(b_cs, b_en, b_mbsel, b_wnr, ACC_WRITE);
  assign b_rd = mbx_hit(b_cs, b_en, b_mbsel, b_wnr, ACC_READ);

  mbx_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_ab_n),
    .wr_req(a_wr), .wr_data(a_wdata), .wr_ready(a_send_ready),
    .rd_req(b_rd), .rd_full(b_mail_full), .rd_data(b_rdata)
  );

  mbx_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_ba_n),
    .wr_req(b_wr), .wr_data(b_wdata), .wr_ready(b_send_ready),
    .rd_req(a_rd), .rd_full(a_mail_full), .rd_data(a_rdata)
  );
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_ab_n,
  input logic          rst_ba_n,
  input logic          a_cs,
  input logic          a_en,
  input logic          a_mbsel,
  input logic          a_wnr,
  input logic [DW-1:0] a_rdata,
  input logic          a_mail_full,
  input logic          a_send_ready,
  input logic          b_cs,
  input logic          b_en,
  input logic          b_mbsel,
  input logic          b_wnr,
  input logic [DW-1:0] b_rdata,
  input logic          b_mail_full,
  input logic          b_send_ready
);
  a_r4_busy_after_write_a: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
    (a_cs && a_en && a_mbsel && a_wnr && a_send_ready) |=> !a_send_ready);

  a_r4_busy_after_write_b: assert property (@(posedge clk_b) disable iff (!rst_ba_n)
    (b_cs && b_en && b_mbsel && b_wnr && b_send_ready) |=> !b_send_ready);

  a_r6_read_clears_b: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
    (b_cs && b_en && b_mbsel && !b_wnr && b_mail_full) |=> !b_mail_full);

  a_r6_read_clears_a: assert property (@(posedge clk_a) disable iff (!rst_ba_n)
    (a_cs && a_en && a_mbsel && !a_wnr && a_mail_full) |=> !a_mail_full);

  a_r7_data_stable_b: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
    b_mail_full |-> $stable(b_rdata));

  a_r7_data_stable_a: assert property (@(posedge clk_a) disable iff (!rst_ba_n)
    a_mail_full |-> $stable(a_rdata));

  a_r5_no_overwrite_ab: assert property (@(posedge clk_b) disable iff (!rst_ab_n)
    b_mail_full |-> !a_send_ready);

  a_r5_no_overwrite_ba: assert property (@(posedge clk_a) disable iff (!rst_ba_n)
    a_mail_full |-> !b_send_ready);
endmodule

bind mbx_bridge mbx_bridge_chk #(.DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
  .a_cs(a_cs), .a_en(a_en), .a_mbsel(a_mbsel), .a_wnr(a_wnr),
  .a_rdata(a_rdata), .a_mail_full(a_mail_full), .a_send_ready(a_send_ready),
  .b_cs(b_cs), .b_en(b_en), .b_mbsel(b_mbsel), .b_wnr(b_wnr),
  .b_rdata(b_rdata), .b_mail_full(b_mail_full), .b_send_ready(b_send_ready)
);

// File: tb/mbx_bridge_tb.sv
module mbx_bridge_tb;
  localparam int DW = 36;
  localparam int LAT = 4; // SYNC_STAGES + 2

  typedef struct packed {
    logic [DW-1:0] ab;
    logic [DW-1:0] ba;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{ab: 36'h000000001, ba: 36'h800000000},
    '{ab: 36'hFFFFFFFFF, ba: 36'h000000000},
    '{ab: 36'hA5A5A5A5A, ba: 36'h5A5A5A5A5},
    '{ab: 36'h123456789, ba: 36'h987654321},
    '{ab: 36'h0F0F0F0F0, ba: 36'hF0F0F0F0F},
    '{ab: 36'h800000000, ba: 36'h000000001}
  };

  logic clk_a = 0, clk_b = 0;
  logic rst_ab_n = 0, rst_ba_n = 0;
  logic a_cs = 0, a_en = 0, a_mbsel = 0, a_wnr = 0;
  logic b_cs = 0, b_en = 0, b_mbsel = 0, b_wnr = 0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_mail_full, a_send_ready, b_mail_full, b_send_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  mbx_bridge u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
    .a_cs(a_cs), .a_en(a_en), .a_mbsel(a_mbsel), .a_wnr(a_wnr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_mail_full(a_mail_full),
    .a_send_ready(a_send_ready),
    .b_cs(b_cs), .b_en(b_en), .b_mbsel(b_mbsel), .b_wnr(b_wnr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_mail_full(b_mail_full),
    .b_send_ready(b_send_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic a_acc(input logic cs, input logic en, input logic sel,
                       input logic wnr, input logic [DW-1:0] d);
    @(posedge clk_a); #1;
    a_cs = cs; a_en = en; a_mbsel = sel; a_wnr = wnr; a_wdata = d;
    @(posedge clk_a); #1;
    a_cs = 0; a_en = 0; a_mbsel = 0; a_wnr = 0;
  endtask

  task automatic b_acc(input logic cs, input logic en, input logic sel,
                       input logic wnr, input logic [DW-1:0] d);
    @(posedge clk_b); #1;
    b_cs = cs; b_en = en; b_mbsel = sel; b_wnr = wnr; b_wdata = d;
    @(posedge clk_b); #1;
    b_cs = 0; b_en = 0; b_mbsel = 0; b_wnr = 0;
  endtask

  task automatic wait_b(input bit want_full, output int n);
    n = 0;
    while ((want_full ? !b_mail_full : !a_send_ready) && n < 20) begin
      if (want_full) @(posedge clk_b); else @(posedge clk_a);
      #1; n++;
    end
  endtask

  task automatic wait_a(input bit want_full, output int n);
    n = 0;
    while ((want_full ? !a_mail_full : !b_send_ready) && n < 20) begin
      if (want_full) @(posedge clk_a); else @(posedge clk_b);
      #1; n++;
    end
  endtask

  task automatic idle_b(input int n);
    repeat (n) @(posedge clk_b);
    #1;
  endtask

  initial begin
    repeat (60000) @(posedge clk_a);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(posedge clk_b);
    #1;
    chk("R1 b_mail_full in reset", b_mail_full, 0);
    chk("R1 a_mail_full in reset", a_mail_full, 0);
    rst_ab_n = 1; rst_ba_n = 1;
    repeat (3) @(posedge clk_b);
    #1;
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    chk("R1 a_send_ready", a_send_ready, 1);
    chk("R1 b_send_ready", b_send_ready, 1);

    // Vector table: both directions in flight together (R11).
    foreach (VECS[i]) begin
      a_acc(1, 1, 1, 1, VECS[i].ab);
      chk("R4 a_send_ready after write", a_send_ready, 0);
      b_acc(1, 1, 1, 1, VECS[i].ba);
      chk("R4 b_send_ready after write", b_send_ready, 0);
      wait_b(1, n);
      chk("R2 b_mail_full within latency", {63'd0, b_mail_full && n <= LAT}, 1);
      chk("R11 b_rdata word", b_rdata, VECS[i].ab);
      wait_a(1, n);
      chk("R3 a_mail_full raised", a_mail_full, 1);
      chk("R3 a_rdata word", a_rdata, VECS[i].ba);
      b_acc(1, 1, 1, 0, '0);
      chk("R6 b_mail_full after read", b_mail_full, 0);
      wait_b(0, n);
      chk("R6 a_send_ready returns", {63'd0, a_send_ready && n <= LAT}, 1);
      a_acc(1, 1, 1, 0, '0);
      chk("R6 a_mail_full after read", a_mail_full, 0);
      wait_a(0, n);
      chk("R6 b_send_ready returns", {63'd0, b_send_ready && n <= LAT}, 1);
    end

    // R8: one qualifier missing each time.
    for (int k = 0; k < 4; k++) begin
      a_acc(k != 0, k != 1, k != 2, k != 3, 36'hDEADBEEF0);
      idle_b(8);
      chk("R8 b_mail_full stays low", b_mail_full, 0);
      chk("R8 a_send_ready stays high", a_send_ready, 1);
    end

    // R9 / R5 / R7: partial reads and writes while busy.
    a_acc(1, 1, 1, 1, 36'h123456789);
    wait_b(1, n);
    b_acc(1, 1, 0, 0, '0);
    chk("R9 read without mbsel keeps flag", b_mail_full, 1);
    b_acc(1, 0, 1, 0, '0);
    chk("R9 read without en keeps flag", b_mail_full, 1);
    a_acc(1, 1, 1, 1, 36'hBADBADBAD);
    idle_b(8);
    chk("R5 waiting word kept", b_rdata, 36'h123456789);
    chk("R7 flag still high", b_mail_full, 1);
    b_acc(1, 1, 1, 0, '0);
    wait_b(0, n);
    idle_b(8);
    chk("R5 no second mail", b_mail_full, 0);

    // R10: reset one direction with mail waiting in both.
    a_acc(1, 1, 1, 1, 36'h0000A5A5A);
    b_acc(1, 1, 1, 1, 36'h00005A5A5);
    wait_b(1, n);
    wait_a(1, n);
    @(posedge clk_a); #1;
    rst_ab_n = 0;
    idle_b(3);
    chk("R10 b_mail_full cleared", b_mail_full, 0);
    chk("R10 b_rdata cleared", b_rdata, 0);
    rst_ab_n = 1;
    idle_b(4);
    chk("R10 a_send_ready after release", a_send_ready, 1);
    chk("R10 other direction flag kept", a_mail_full, 1);
    chk("R10 other direction word kept", a_rdata, 36'h00005A5A5);
    chk("R10 other direction still busy", b_send_ready, 0);
    a_acc(1, 1, 1, 0, '0);
    wait_a(0, n);
    chk("R6 b_send_ready after late read", b_send_ready, 1);

    // R2 again after the direction reset.
    a_acc(1, 1, 1, 1, 36'h777777777);
    wait_b(1, n);
    chk("R2 write after direction reset", b_rdata, 36'h777777777);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule